// File: doc/BRIEF.md
# Transition-Kicked Watchdog Timer

This block supervises a processor's liveness line. The processor toggles `wdi` while it runs; each accepted level change, rising or falling, restarts an internal cycle counter. When the line stays at one level for longer than the configured number of clock cycles, the active-low fault output `wdo_n` drops. It stays low until the next accepted change on `wdi`. There is no way to switch the watchdog off. A supply-good flag `vcc_ok` overrides everything: while it is false, `wdo_n` is held low. When it returns, the count starts again from zero.

`wdi` is asynchronous. It passes through a two-flop synchronizer and then a stability filter, which accepts a new level only after it has been seen on `MIN_PULSE_CYC` consecutive clock edges. Shorter pulses are discarded. The fault output is a plain flag: it only resets the system if the integrator wires it into a reset input. The timeout is `TIMEOUT_CYC` cycles and the minimum pulse is `MIN_PULSE_CYC` cycles; both are parameters.

Top module: `wdi_activity_watchdog`

## Requirements
- R1: While `por_n` is low, `wdo_n` is high. After release, if `wdi` stays at 0, `wdo_n` is still high after rising edge TIMEOUT_CYC and is low after rising edge TIMEOUT_CYC+1. Edges are counted from the first rising edge after release. A timed-out output stays low while `wdi` does not change.
- R2: A rising change and a falling change on `wdi` both restart the timeout.
- R3: Take an accepted `wdi` change and number the rising edges after it, starting at 1. If `wdi` then holds, `wdo_n` (low means fault) is high after edge TIMEOUT_CYC+MIN_PULSE_CYC+3 and low after edge TIMEOUT_CYC+MIN_PULSE_CYC+4. The internal count never passes TIMEOUT_CYC.
- R4: A second change driven TIMEOUT_CYC+1 cycles after the first prevents the fault. A second change driven TIMEOUT_CYC+2 cycles after the first lets `wdo_n` go low after edge TIMEOUT_CYC+MIN_PULSE_CYC+4 of the first change.
- R5: A level held on `wdi` for MIN_PULSE_CYC-1 cycles has no effect on the timeout. A level held for MIN_PULSE_CYC cycles counts as a change.
- R6: After a timeout, an accepted change releases `wdo_n`. It is still low after edge MIN_PULSE_CYC+2 of that change and high after edge MIN_PULSE_CYC+3.
- R7: While `vcc_ok` is low, `wdo_n` is low from the first rising edge onward, whatever `wdi` does.
- R8: When `vcc_ok` returns high with `wdi` held, `wdo_n` is high after the first rising edge. It is still high after edge TIMEOUT_CYC and low after edge TIMEOUT_CYC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous assert, deasserted synchronously to `clk` |
| wdi | input | 1 | Asynchronous activity line from the processor |
| vcc_ok | input | 1 | Supply-good flag, synchronous to `clk` |
| wdo_n | output | 1 | Watchdog fault, active low, registered |

## Verification
The assertions assume `vcc_ok` is already synchronous to `clk`, because it drives the output state machine directly. They also assume `por_n` is released away from a rising edge. The bench changes both signals only on falling clock edges. The bench holds `wdi` at 0 through the power-on clear, so the filter's reset level matches the line and no change is accepted at release. Every `wdi` level the bench means as a real change lasts at least MIN_PULSE_CYC cycles. The only exception is the deliberate short pulse that checks rejection.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [1:0] {
    WD_RUN  = 2'd0,
    WD_TRIP = 2'd1,
    WD_UVLO = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdk_filter.sv
module wdk_filter #(
  parameter int MIN_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic kick_o
);
  localparam int CW = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE_CYC - 1);

  logic          acc_q, acc_d;
  logic [CW-1:0] run_q, run_d;
  logic          kick_q, kick_d;

  always_comb begin
    acc_d  = acc_q;
    run_d  = '0;
    kick_d = 1'b0;
    if (lvl_i != acc_q) begin
      if (run_q == LAST) begin
        acc_d  = lvl_i;
        kick_d = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      run_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      run_q  <= run_d;
      kick_q <= kick_d;
    end
  end

  assign kick_o = kick_q;

  // R5: a newly accepted level is the one the synchronizer presented
  assert_accept_matches_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> ($past(lvl_i) == acc_q));

  // R5: the run counter never passes the acceptance point
  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic exp_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);

  always_comb begin
    if (clr_i)         cnt_d = '0;
    else if (at_limit) cnt_d = cnt_q;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign exp_o = at_limit;

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  assert_clear_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_expiry_after_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_o) |-> ($past(cnt_q) == LIMIT - 1'b1));
endmodule

// File: rtl/wdi_activity_watchdog.sv
module wdi_activity_watchdog
  import wdk_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 1600000,
  parameter int MIN_PULSE_CYC = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic wdi,
  input  logic vcc_ok,
  output logic wdo_n
);
  logic      wdi_s;
  logic      kick;
  logic      expired;
  logic      tmr_clr;
  wd_state_e state_q, state_d;

  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_i   (wdi),
    .q_o   (wdi_s)
  );

  wdk_filter #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_filter (
    .clk    (clk),
    .rst_n  (por_n),
    .lvl_i  (wdi_s),
    .kick_o (kick)
  );

  // Undervoltage holds the count at zero so it restarts on recovery
  assign tmr_clr = kick | ~vcc_ok;

  wdk_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (por_n),
    .clr_i (tmr_clr),
    .exp_o (expired)
  );

  always_comb begin
    state_d = state_q;
    if (!vcc_ok) begin
      state_d = WD_UVLO;
    end else begin
      case (state_q)
        WD_RUN:  if (expired && !kick) state_d = WD_TRIP;
        WD_TRIP: if (kick)             state_d = WD_RUN;
        WD_UVLO:                       state_d = WD_RUN;
        default:                       state_d = WD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= WD_RUN;
    else        state_q <= state_d;
  end

  assign wdo_n = (state_q == WD_RUN);

  assert_undervolt_low_R7: assert property (@(posedge clk) disable iff (!por_n)
    !vcc_ok |=> !wdo_n);

  assert_kick_releases_R6: assert property (@(posedge clk) disable iff (!por_n)
    (kick && vcc_ok) |=> wdo_n);

  assert_fault_needs_expiry_R3: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(wdo_n) && $past(vcc_ok)) |-> $past(expired));

  assert_recovery_releases_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(vcc_ok) |=> wdo_n);
endmodule

// File: tb/wdi_activity_watchdog_test.sv
module wdi_activity_watchdog_test;
  localparam int T = 50;
  localparam int M = 4;

  logic clk = 1'b0;
  logic por_n, wdi, vcc_ok;
  logic wdo_n;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  typedef struct {
    int    at;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdi_activity_watchdog #(.TIMEOUT_CYC(T), .MIN_PULSE_CYC(M)) uut (
    .clk(clk), .por_n(por_n), .wdi(wdi), .vcc_ok(vcc_ok), .wdo_n(wdo_n)
  );

  // Driver side: queue an expected wdo_n value after absolute edge 'at'
  task automatic push(input int at, input bit val, input string tag);
    exp_t e;
    int idx;
    e.at = at; e.val = val; e.tag = tag;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin idx = i; break; end
    end
    sb.insert(idx, e);
  endtask

  task automatic check_now(input bit val, input string tag);
    checks++;
    if (wdo_n !== val) begin
      errors++;
      $display("FAIL %s cyc=%0d wdo_n actual=%b expected=%b", tag, cyc, wdo_n, val);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations as the design reaches them
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at < cyc || wdo_n !== e.val) begin
        errors++;
        $display("FAIL %s at=%0d cyc=%0d wdo_n actual=%b expected=%b",
                 e.tag, e.at, cyc, wdo_n, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, b, x, y;
    por_n = 1'b0; wdi = 1'b0; vcc_ok = 1'b1;
    wait_cyc(3);
    check_now(1'b1, "R1 during clear");
    por_n = 1'b1;
    a = cyc;
    push(a + T,      1'b1, "R1 before first timeout");
    push(a + T + 1,  1'b0, "R1 first timeout");
    push(a + T + 10, 1'b0, "R1 stays low without change");
    wait_cyc(T + 15);

    // R6 release and R2 rising change, then R3 exact boundary
    a = cyc; wdi = 1'b1;
    push(a + M + 2,     1'b0, "R6 still low");
    push(a + M + 3,     1'b1, "R6 released");
    push(a + T + M + 3, 1'b1, "R3 last high");
    push(a + T + M + 4, 1'b0, "R3 fault after rising change");
    wait_cyc(T + M + 10);

    // R2 falling change, R4 latest safe second change
    a = cyc; wdi = 1'b0;
    push(a + M + 3, 1'b1, "R2 falling change releases");
    wait_cyc(T + 1);
    b = cyc; wdi = 1'b1;
    push(a + T + M + 4, 1'b1, "R4 safe change prevents fault");
    push(b + T + M + 3, 1'b1, "R4 high before own expiry");
    push(b + T + M + 4, 1'b0, "R4 fault after second change");
    wait_cyc(T + M + 10);

    // R4 one cycle too late
    a = cyc; wdi = 1'b0;
    push(a + M + 3, 1'b1, "R6 released again");
    wait_cyc(T + 2);
    b = cyc; wdi = 1'b1;
    push(a + T + M + 3, 1'b1, "R4 high before late expiry");
    push(a + T + M + 4, 1'b0, "R4 late change does not prevent fault");
    push(b + M + 3,     1'b1, "R4 late change releases");
    wait_cyc(M + 10);

    // R5 short pulse rejected
    x = cyc; wdi = 1'b0;
    wait_cyc(M - 1);
    wdi = 1'b1;
    push(b + T + M + 3, 1'b1, "R5 short pulse ignored, still high");
    push(b + T + M + 4, 1'b0, "R5 short pulse ignored, fault on time");
    wait_cyc(T);

    // R5 pulse of exactly the minimum width counts twice
    x = cyc; wdi = 1'b0;
    wait_cyc(M);
    y = cyc; wdi = 1'b1;
    push(x + M + 3,     1'b1, "R5 minimum pulse accepted");
    push(y + T + M + 3, 1'b1, "R5 trailing change restarted timer");
    push(y + T + M + 4, 1'b0, "R5 fault after trailing change");
    wait_cyc(T + M + 10);

    // Return to running, then undervoltage
    a = cyc; wdi = 1'b0;
    push(a + M + 3, 1'b1, "R6 running before undervoltage");
    wait_cyc(M + 8);
    a = cyc; vcc_ok = 1'b0;
    push(a + 1, 1'b0, "R7 undervoltage forces low");
    wait_cyc(5);
    wdi = 1'b1;
    wait_cyc(M + 5);
    wdi = 1'b0;
    push(a + 30, 1'b0, "R7 changes ignored under undervoltage");
    push(a + 40, 1'b0, "R7 still low");
    wait_cyc(35);
    b = cyc; vcc_ok = 1'b1;
    push(b + 1,     1'b1, "R8 recovery releases");
    push(b + T,     1'b1, "R8 count restarted");
    push(b + T + 1, 1'b0, "R8 timeout after recovery");
    wait_cyc(T + 10);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3 pending expectations actual=%0d expected=0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule